// File: doc/BRIEF.md
# Byte Load Sequencer for an 8-bit Sound CPU

This block fetches, decodes and executes the register-load subset of a small 8-bit processor. Each supported opcode moves one byte from memory into the accumulator or one of the two index registers. The operand may be an immediate byte, a byte in the direct page, a direct-page byte offset by an index, an absolute byte, an absolute byte offset by an index, a byte addressed through the X register (optionally bumping X afterwards), or a byte reached through a 16-bit pointer kept in the direct page. A byte-wide asynchronous read port is driven from a 16-bit program counter and from internally computed effective addresses.

The sequencer runs one CPU cycle per enable pulse, and the enable is generated internally every `CLK_DIV` base clocks. Every instruction spends exactly its defined number of CPU cycles. Only the negative and zero bits of the status byte are ever written. Any opcode outside the subset stops the sequencer for good, until reset, and raises a flag. A one-clock completion strobe follows each instruction so that timing can be measured from outside.

Top module: `load_exec`

## Requirements
- R1: While and right after reset, `reg_a`, `reg_x`, `reg_y` and `status` read 0, `pc` equals `reset_vec`, and `instr_done` and `bad_op` are 0.
- R2: Immediate loads take the byte after the opcode: E8 loads A, CD loads X, 8D loads Y. Each is 2 bytes and 2 CPU cycles, and `pc` advances by 2.
- R3: Direct loads read address {page, d}, where d is the operand byte and page is 0 because status bit 5 stays clear. E4 loads A, F8 loads X and EB loads Y, each in 2 bytes and 3 cycles.
- R4: Direct indexed loads read {page, (d + index) mod 256}, so the sum wraps inside the page. F4 loads A using X, F9 loads X using Y, and FB loads Y using X. Each is 2 bytes and 4 cycles.
- R5: Absolute loads take the low address byte first and then the high byte, and are 3 bytes long. E5 (A), E9 (X) and EC (Y) take 4 cycles. F5 (A plus X) and F6 (A plus Y) take 5 cycles, with a full 16-bit sum that carries into the high byte.
- R6: E6 loads A from {page, X} in 1 byte and 3 cycles. BF does the same in 4 cycles and then increments X modulo 256.
- R7: E7 forms a pointer from the direct-page bytes at (d+X) and (d+X+1). F7 forms a pointer from the bytes at d and d+1 and adds Y to it with a 16-bit carry. In both, the pointer high byte is taken from the next offset wrapped inside the page. Both are 2 bytes and 6 cycles.
- R8: Each load sets status bit 7 (N) to bit 7 of the loaded byte and status bit 1 (Z) when the byte is zero. Bits 6..2 and 0 never change. In BF the flags follow the loaded byte, not X.
- R9: One CPU cycle lasts `CLK_DIV` base clocks (default 2). `instr_done` is high for exactly one base clock after each instruction's last cycle, so successive pulses are `CLK_DIV` × cycles apart. Registers only change together with that pulse.
- R10: The program counter wraps modulo 65536.
- R11: An opcode outside the subset sets `bad_op`, which stays set until reset. `pc` then holds the address of that opcode, memory is no longer read, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_vec | input | 16 | Start address loaded into the program counter at reset |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | High in the base clock where read data is consumed |
| mem_rdata | input | 8 | Combinational read data for `mem_addr` |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | X index register |
| reg_y | output | 8 | Y index register |
| status | output | 8 | Status byte, N at bit 7 and Z at bit 1 |
| pc | output | 16 | Program counter |
| instr_done | output | 1 | One-clock pulse after each completed instruction |
| bad_op | output | 1 | Sticky unsupported-opcode flag |

## Verification
An internal step counter that drifts shows up at once as a changed spacing between two `instr_done` pulses. Because the next opcode is then fetched from the wrong place, the following instruction also shows it. A wrong effective address, index, pointer byte or carry appears in the destination register at the very next completion pulse. The memory is seeded with a distinct decoy byte at every address that a page-wrap or carry fault would reach instead, so the loaded value names the fault. A halt that is not sticky shows within a few clocks as `pc` moving or a read strobe on a halted sequencer.

// File: rtl/load_exec_pkg.sv
package load_exec_pkg;

    localparam int unsigned AW       = 16;
    localparam int unsigned DW       = 8;
    localparam int unsigned STEP_W   = 3;
    localparam int unsigned FLG_N    = 7;
    localparam int unsigned FLG_PAGE = 5;
    localparam int unsigned FLG_Z    = 1;

    typedef enum logic [1:0] {
        DST_A = 2'd0,
        DST_X = 2'd1,
        DST_Y = 2'd2
    } dst_e;

    typedef enum logic [3:0] {
        AM_IMM     = 4'd0,
        AM_XIND    = 4'd1,
        AM_XINC    = 4'd2,
        AM_DP      = 4'd3,
        AM_DPIDX   = 4'd4,
        AM_ABS     = 4'd5,
        AM_ABSIDX  = 4'd6,
        AM_PREIDX  = 4'd7,
        AM_POSTIDX = 4'd8
    } amode_e;

    typedef struct packed {
        logic              legal;
        dst_e              dst;
        amode_e            mode;
        logic              use_y;
        logic [1:0]        nbytes;
        logic [STEP_W-1:0] ncyc;
    } op_info_t;

    typedef struct packed {
        logic [AW-1:0]     pc;
        logic [DW-1:0]     a;
        logic [DW-1:0]     x;
        logic [DW-1:0]     y;
        logic [DW-1:0]     psw;
        logic [STEP_W-1:0] step;
        op_info_t          op;
        logic [AW-1:0]     ea;
        logic [DW-1:0]     lo;
        logic              halt;
        logic              done;
    } exec_st_t;

endpackage

// File: rtl/load_exec_cdiv.sv
module load_exec_cdiv #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic ce
);
    generate
        if (DIV < 2) begin : g_pass
            assign ce = 1'b1;
        end else begin : g_div
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign ce = (cnt_q == LAST);

            // R9: an enable pulse never lasts two base clocks
            a_r9_ce_single: assert property (@(posedge clk) disable iff (!rst_n)
                ce |=> !ce);
        end
    endgenerate
endmodule

// File: rtl/load_exec_decode.sv
module load_exec_decode
    import load_exec_pkg::*;
(
    input  logic [DW-1:0] opcode,
    output op_info_t      info
);
    always_comb begin
        info       = '0;
        info.legal = 1'b1;
        info.dst   = DST_A;
        info.mode  = AM_IMM;
        info.use_y = 1'b0;
        case (opcode)
            8'hE8: {info.dst, info.mode}              = {DST_A, AM_IMM};
            8'hE6: {info.dst, info.mode}              = {DST_A, AM_XIND};
            8'hBF: {info.dst, info.mode}              = {DST_A, AM_XINC};
            8'hE4: {info.dst, info.mode}              = {DST_A, AM_DP};
            8'hF4: {info.dst, info.mode}              = {DST_A, AM_DPIDX};
            8'hE5: {info.dst, info.mode}              = {DST_A, AM_ABS};
            8'hF5: {info.dst, info.mode}              = {DST_A, AM_ABSIDX};
            8'hF6: {info.dst, info.mode, info.use_y}  = {DST_A, AM_ABSIDX, 1'b1};
            8'hE7: {info.dst, info.mode}              = {DST_A, AM_PREIDX};
            8'hF7: {info.dst, info.mode, info.use_y}  = {DST_A, AM_POSTIDX, 1'b1};
            8'hCD: {info.dst, info.mode}              = {DST_X, AM_IMM};
            8'hF8: {info.dst, info.mode}              = {DST_X, AM_DP};
            8'hF9: {info.dst, info.mode, info.use_y}  = {DST_X, AM_DPIDX, 1'b1};
            8'hE9: {info.dst, info.mode}              = {DST_X, AM_ABS};
            8'h8D: {info.dst, info.mode}              = {DST_Y, AM_IMM};
            8'hEB: {info.dst, info.mode}              = {DST_Y, AM_DP};
            8'hFB: {info.dst, info.mode}              = {DST_Y, AM_DPIDX};
            8'hEC: {info.dst, info.mode}              = {DST_Y, AM_ABS};
            default: info.legal = 1'b0;
        endcase

        case (info.mode)
            AM_IMM:     {info.nbytes, info.ncyc} = {2'd2, STEP_W'(2)};
            AM_XIND:    {info.nbytes, info.ncyc} = {2'd1, STEP_W'(3)};
            AM_XINC:    {info.nbytes, info.ncyc} = {2'd1, STEP_W'(4)};
            AM_DP:      {info.nbytes, info.ncyc} = {2'd2, STEP_W'(3)};
            AM_DPIDX:   {info.nbytes, info.ncyc} = {2'd2, STEP_W'(4)};
            AM_ABS:     {info.nbytes, info.ncyc} = {2'd3, STEP_W'(4)};
            AM_ABSIDX:  {info.nbytes, info.ncyc} = {2'd3, STEP_W'(5)};
            default:    {info.nbytes, info.ncyc} = {2'd2, STEP_W'(6)};
        endcase
    end
endmodule

// File: rtl/load_exec_agen.sv
module load_exec_agen
    import load_exec_pkg::*;
(
    input  amode_e            mode,
    input  logic              use_y,
    input  logic [1:0]        nbytes,
    input  logic [STEP_W-1:0] ncyc,
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     ea,
    input  logic [DW-1:0]     lo,
    input  logic [DW-1:0]     rdata,
    input  logic [DW-1:0]     x,
    input  logic [DW-1:0]     y,
    input  logic [DW-1:0]     page,
    output logic [AW-1:0]     addr,
    output logic              rd,
    output logic              pc_inc,
    output logic              last,
    output logic [AW-1:0]     ea_nx,
    output logic [DW-1:0]     lo_nx
);
    logic [DW-1:0] idx, pg_idx, pg_x, pg_nx;
    logic [AW-1:0] full_idx;
    logic          opnd;

    always_comb begin
        idx      = use_y ? y : x;
        pg_idx   = ea[DW-1:0] + idx;
        pg_x     = ea[DW-1:0] + x;
        pg_nx    = ea[DW-1:0] + 8'd1;
        full_idx = ea + AW'(idx);
        last     = (step != '0) && (step == ncyc - 1'b1);
        opnd     = (step != '0) && (step < STEP_W'(nbytes));

        addr   = pc;
        rd     = 1'b0;
        pc_inc = 1'b0;
        ea_nx  = ea;
        lo_nx  = lo;

        if (step == '0) begin
            rd     = 1'b1;
            pc_inc = 1'b1;
        end else if (last) begin
            rd = 1'b1;
            if (mode == AM_IMM) pc_inc = 1'b1;
            else                addr   = ea;
        end else if (opnd) begin
            rd     = 1'b1;
            pc_inc = 1'b1;
            if ((mode == AM_ABS) || (mode == AM_ABSIDX)) begin
                if (step == STEP_W'(1)) lo_nx = rdata;
                else                    ea_nx = {rdata, lo};
            end else begin
                ea_nx = {page, rdata};
            end
        end else begin
            case (mode)
                AM_XIND, AM_XINC: ea_nx = {page, x};
                AM_DPIDX:         ea_nx = {page, pg_idx};
                AM_ABSIDX:        ea_nx = full_idx;
                AM_PREIDX: begin
                    if (step == STEP_W'(2)) begin
                        ea_nx = {page, pg_x};
                    end else if (step == STEP_W'(3)) begin
                        rd    = 1'b1;
                        addr  = ea;
                        lo_nx = rdata;
                        ea_nx = {page, pg_nx};
                    end else begin
                        rd    = 1'b1;
                        addr  = ea;
                        ea_nx = {rdata, lo};
                    end
                end
                AM_POSTIDX: begin
                    if (step == STEP_W'(2)) begin
                        rd    = 1'b1;
                        addr  = ea;
                        lo_nx = rdata;
                        ea_nx = {page, pg_nx};
                    end else if (step == STEP_W'(3)) begin
                        rd    = 1'b1;
                        addr  = ea;
                        ea_nx = {rdata, lo};
                    end else begin
                        ea_nx = full_idx;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/load_exec.sv
module load_exec
    import load_exec_pkg::*;
#(
    parameter int unsigned CLK_DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reset_vec,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] reg_a,
    output logic [DW-1:0] reg_x,
    output logic [DW-1:0] reg_y,
    output logic [DW-1:0] status,
    output logic [AW-1:0] pc,
    output logic          instr_done,
    output logic          bad_op
);
    exec_st_t      st_d, st_q, rst_val;
    op_info_t      dec;
    logic          ce;
    logic [AW-1:0] ag_addr, ag_ea;
    logic [DW-1:0] ag_lo, page;
    logic          ag_rd, ag_pc_inc, ag_last;

    load_exec_cdiv #(.DIV(CLK_DIV)) u_cdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce)
    );

    load_exec_decode u_decode (
        .opcode (mem_rdata),
        .info   (dec)
    );

    assign page = {{(DW-1){1'b0}}, st_q.psw[FLG_PAGE]};

    load_exec_agen u_agen (
        .mode   (st_q.op.mode),
        .use_y  (st_q.op.use_y),
        .nbytes (st_q.op.nbytes),
        .ncyc   (st_q.op.ncyc),
        .step   (st_q.step),
        .pc     (st_q.pc),
        .ea     (st_q.ea),
        .lo     (st_q.lo),
        .rdata  (mem_rdata),
        .x      (st_q.x),
        .y      (st_q.y),
        .page   (page),
        .addr   (ag_addr),
        .rd     (ag_rd),
        .pc_inc (ag_pc_inc),
        .last   (ag_last),
        .ea_nx  (ag_ea),
        .lo_nx  (ag_lo)
    );

    always_comb begin
        rst_val    = '0;
        rst_val.pc = reset_vec;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (ce && !st_q.halt) begin
            if (st_q.step == '0) begin
                if (!dec.legal) begin
                    st_d.halt = 1'b1;
                end else begin
                    st_d.op   = dec;
                    st_d.pc   = st_q.pc + 1'b1;
                    st_d.step = STEP_W'(1);
                end
            end else begin
                st_d.ea = ag_ea;
                st_d.lo = ag_lo;
                if (ag_pc_inc) st_d.pc = st_q.pc + 1'b1;
                if (ag_last) begin
                    st_d.step = '0;
                    st_d.done = 1'b1;
                    case (st_q.op.dst)
                        DST_X:   st_d.x = mem_rdata;
                        DST_Y:   st_d.y = mem_rdata;
                        default: st_d.a = mem_rdata;
                    endcase
                    if (st_q.op.mode == AM_XINC) st_d.x = st_q.x + 1'b1;
                    st_d.psw[FLG_N] = mem_rdata[DW-1];
                    st_d.psw[FLG_Z] = (mem_rdata == '0);
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rst_val;
        else        st_q <= st_d;
    end

    assign mem_addr   = ag_addr;
    assign mem_rd     = ce && !st_q.halt && ag_rd;
    assign reg_a      = st_q.a;
    assign reg_x      = st_q.x;
    assign reg_y      = st_q.y;
    assign status     = st_q.psw;
    assign pc         = st_q.pc;
    assign instr_done = st_q.done;
    assign bad_op     = st_q.halt;

    // R9: completion strobe lasts one base clock and follows an enable
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);
    a_r9_done_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> $past(ce));
    // R9: architectural registers only move with the completion strobe
    a_r9_regs_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(reg_a) && $stable(reg_x) && $stable(reg_y) && $stable(status)) |-> instr_done);
    // R8: only N and Z are ever written
    a_r8_other_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 8'h7D) == 8'h00);
    // R11: halt is sticky, freezes the counter and stops reads
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |=> bad_op && $stable(pc) && $stable(reg_a));
    a_r11_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> !mem_rd);
endmodule

// File: tb/load_exec_bench.sv
module load_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reset_vec = 16'h0000;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic [7:0]  reg_a, reg_x, reg_y, status;
    logic [15:0] pc;
    logic        instr_done, bad_op;

    logic [7:0]  mem [0:4095];
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:0]];

    load_exec u_load_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .reset_vec  (reset_vec),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_rdata  (mem_rdata),
        .reg_a      (reg_a),
        .reg_x      (reg_x),
        .reg_y      (reg_y),
        .status     (status),
        .pc         (pc),
        .instr_done (instr_done),
        .bad_op     (bad_op)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic put(input int addr, input logic [7:0] v);
        mem[addr[11:0]] = v;
    endtask

    task automatic start(input logic [15:0] vec);
        rst_n = 1'b0;
        reset_vec = vec;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // counts base clocks up to the completion strobe: R9 spacing
    task automatic run_one(input string req, input int ncyc);
        int clks = 0;
        do begin
            @(negedge clk);
            clks++;
        end while (!instr_done && clks < 100);
        chk({req, "/R9"}, "clocks per instruction", clks, 2 * ncyc);
    endtask

    task automatic regs(input string req, input int a, input int x, input int y,
                        input int st, input int p);
        chk(req, "A", int'(reg_a), a);
        chk(req, "X", int'(reg_x), x);
        chk(req, "Y", int'(reg_y), y);
        chk({req, "/R8"}, "status", int'(status), st);
        chk(req, "PC", int'(pc), p);
    endtask

    task automatic t_reset;
        put(16'h0123, 8'hE8);
        start(16'h0123);
        regs("R1", 0, 0, 0, 0, 16'h0123);
        chk("R1", "instr_done", int'(instr_done), 0);
        chk("R1", "bad_op", int'(bad_op), 0);
    endtask

    task automatic t_imm;
        put(16'h0100, 8'hE8); put(16'h0101, 8'h80);
        put(16'h0102, 8'hCD); put(16'h0103, 8'h00);
        put(16'h0104, 8'h8D); put(16'h0105, 8'h7F);
        start(16'h0100);
        run_one("R2", 2); regs("R2", 8'h80, 0, 0, 8'h80, 16'h0102);
        run_one("R2", 2); regs("R2", 8'h80, 0, 0, 8'h02, 16'h0104);
        run_one("R2", 2); regs("R2", 8'h80, 0, 8'h7F, 8'h00, 16'h0106);
    endtask

    task automatic t_direct;
        put(16'h0010, 8'h00); put(16'h0015, 8'h9C); put(16'h0011, 8'h44);
        put(16'h0012, 8'h81); put(16'h0013, 8'h66); put(16'h0113, 8'hEE);
        put(16'h0064, 8'h37); put(16'h0164, 8'hEE);
        put(16'h0200, 8'hCD); put(16'h0201, 8'h05);
        put(16'h0202, 8'h8D); put(16'h0203, 8'hF0);
        put(16'h0204, 8'hE4); put(16'h0205, 8'h10);
        put(16'h0206, 8'hF4); put(16'h0207, 8'h10);
        put(16'h0208, 8'hF8); put(16'h0209, 8'h11);
        put(16'h020A, 8'hF9); put(16'h020B, 8'h23);
        put(16'h020C, 8'hEB); put(16'h020D, 8'h12);
        put(16'h020E, 8'hFB); put(16'h020F, 8'hFE);
        start(16'h0200);
        run_one("R2", 2); run_one("R2", 2);
        run_one("R3", 3); regs("R3", 8'h00, 8'h05, 8'hF0, 8'h02, 16'h0206);
        run_one("R4", 4); regs("R4", 8'h9C, 8'h05, 8'hF0, 8'h80, 16'h0208);
        run_one("R3", 3); regs("R3", 8'h9C, 8'h44, 8'hF0, 8'h00, 16'h020A);
        run_one("R4", 4); regs("R4", 8'h9C, 8'h66, 8'hF0, 8'h00, 16'h020C);
        run_one("R3", 3); regs("R3", 8'h9C, 8'h66, 8'h81, 8'h80, 16'h020E);
        run_one("R4", 4); regs("R4", 8'h9C, 8'h66, 8'h37, 8'h00, 16'h0210);
    endtask

    task automatic t_abs;
        put(16'h0800, 8'h5A); put(16'h0910, 8'hC3); put(16'h0810, 8'hEE);
        put(16'h0900, 8'h00);
        put(16'h0300, 8'hCD); put(16'h0301, 8'h20);
        put(16'h0302, 8'h8D); put(16'h0303, 8'h01);
        put(16'h0304, 8'hE5); put(16'h0305, 8'h00); put(16'h0306, 8'h08);
        put(16'h0307, 8'hF5); put(16'h0308, 8'hF0); put(16'h0309, 8'h08);
        put(16'h030A, 8'hF6); put(16'h030B, 8'hFF); put(16'h030C, 8'h08);
        put(16'h030D, 8'hE9); put(16'h030E, 8'h00); put(16'h030F, 8'h09);
        put(16'h0310, 8'hEC); put(16'h0311, 8'h10); put(16'h0312, 8'h09);
        start(16'h0300);
        run_one("R2", 2); run_one("R2", 2);
        run_one("R5", 4); regs("R5", 8'h5A, 8'h20, 8'h01, 8'h00, 16'h0307);
        run_one("R5", 5); regs("R5", 8'hC3, 8'h20, 8'h01, 8'h80, 16'h030A);
        run_one("R5", 5); regs("R5", 8'h00, 8'h20, 8'h01, 8'h02, 16'h030D);
        run_one("R5", 4); regs("R5", 8'h00, 8'h00, 8'h01, 8'h02, 16'h0310);
        run_one("R5", 4); regs("R5", 8'h00, 8'h00, 8'hC3, 8'h80, 16'h0313);
    endtask

    task automatic t_xind;
        put(16'h0030, 8'hA5); put(16'h0031, 8'h00); put(16'h00FF, 8'h71);
        put(16'h0400, 8'hCD); put(16'h0401, 8'h30);
        put(16'h0402, 8'hE6); put(16'h0403, 8'hBF); put(16'h0404, 8'hBF);
        put(16'h0405, 8'hCD); put(16'h0406, 8'hFF); put(16'h0407, 8'hBF);
        start(16'h0400);
        run_one("R2", 2);
        run_one("R6", 3); regs("R6", 8'hA5, 8'h30, 0, 8'h80, 16'h0403);
        run_one("R6", 4); regs("R6", 8'hA5, 8'h31, 0, 8'h80, 16'h0404);
        run_one("R6", 4); regs("R6", 8'h00, 8'h32, 0, 8'h02, 16'h0405);
        run_one("R2", 2);
        run_one("R6", 4); regs("R6", 8'h71, 8'h00, 0, 8'h00, 16'h0408);
    endtask

    task automatic t_indirect;
        put(16'h0040, 8'h10); put(16'h0041, 8'h0E); put(16'h0E10, 8'hEE);
        put(16'h0044, 8'h00); put(16'h0045, 8'h0A); put(16'h0A00, 8'h8E);
        put(16'h0050, 8'hF0); put(16'h0051, 8'h0A); put(16'h0B10, 8'h29);
        put(16'h0A10, 8'hEE);
        put(16'h00FF, 8'h20); put(16'h0000, 8'h0C); put(16'h0100, 8'h0D);
        put(16'h0C20, 8'h00); put(16'h0D20, 8'hEE);
        put(16'h0C40, 8'hF1); put(16'h0D40, 8'hEE);
        put(16'h0500, 8'hCD); put(16'h0501, 8'h04);
        put(16'h0502, 8'h8D); put(16'h0503, 8'h20);
        put(16'h0504, 8'hE7); put(16'h0505, 8'h40);
        put(16'h0506, 8'hF7); put(16'h0507, 8'h50);
        put(16'h0508, 8'hCD); put(16'h0509, 8'h00);
        put(16'h050A, 8'hE7); put(16'h050B, 8'hFF);
        put(16'h050C, 8'hF7); put(16'h050D, 8'hFF);
        start(16'h0500);
        run_one("R2", 2); run_one("R2", 2);
        run_one("R7", 6); regs("R7", 8'h8E, 8'h04, 8'h20, 8'h80, 16'h0506);
        run_one("R7", 6); regs("R7", 8'h29, 8'h04, 8'h20, 8'h00, 16'h0508);
        run_one("R2", 2);
        run_one("R7", 6); regs("R7", 8'h00, 8'h00, 8'h20, 8'h02, 16'h050C);
        run_one("R7", 6); regs("R7", 8'hF1, 8'h00, 8'h20, 8'h80, 16'h050E);
    endtask

    task automatic t_wrap;
        put(16'hFFFE, 8'hE8); put(16'hFFFF, 8'h42);
        start(16'hFFFE);
        run_one("R10", 2);
        regs("R10", 8'h42, 0, 0, 8'h00, 16'h0000);
    endtask

    task automatic t_illegal;
        int seen_done = 0;
        int seen_rd = 0;
        put(16'h0600, 8'hE8); put(16'h0601, 8'h11); put(16'h0602, 8'h00);
        start(16'h0600);
        run_one("R11", 2);
        chk("R11", "bad_op before", int'(bad_op), 0);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (instr_done) seen_done++;
            if (mem_rd) seen_rd++;
        end
        chk("R11", "bad_op", int'(bad_op), 1);
        chk("R11", "PC held", int'(pc), 16'h0602);
        chk("R11", "A kept", int'(reg_a), 8'h11);
        chk("R11", "done pulses", seen_done, 0);
        chk("R11", "reads", seen_rd, 0);
        put(16'h0680, 8'hBE);
        start(16'h0680);
        repeat (10) @(negedge clk);
        chk("R11", "bad_op second", int'(bad_op), 1);
        chk("R11", "PC second", int'(pc), 16'h0680);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        t_reset;
        t_imm;
        t_direct;
        t_abs;
        t_xind;
        t_indirect;
        t_wrap;
        t_illegal;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule